// File: doc/BRIEF.md
# Byte-wide RAM with BCD calendar clock

This block is a byte-addressed static memory whose eight highest locations form a time-of-day register file instead of storage. Software reads and writes it through a simple synchronous bus: address, write data, write enable, read enable and registered read data. Every address below the register window behaves as ordinary read/write memory. The size parameter picks a 2 KB or 8 KB array, and the register window always sits at the top of the chosen size.

The register file holds a control byte, seconds, minutes, hours, a weekday with a stored century flag, date, month and a two-digit year. Values are presented and accepted in packed BCD. Each clock-field write is masked to the bits that field uses and is dropped when the value is not valid BCD or falls outside the field's range. A 1 Hz tick input advances the calendar through the usual carry chain, unless the stop flag held in the seconds byte is set.

Top module: `tod_ram`

## Requirements
- R1: Writes below the window store a byte and reads there return it. Read data appears on `rdData` one clock after the cycle in which `rdEn` is high, and holds its value while `rdEn` is low.
- R2: The window takes the eight highest addresses (0x7F8..0x7FF when `ADDR_W`=11, 0x1FF8..0x1FFF when `ADDR_W`=13). Its slots, from lowest to highest address, are: control, seconds, minutes, hours, weekday/century, date, month, year.
- R3: A control write stores the value with bit 5 cleared and bits 7 and 4 set. Reading back a control write of 0xFF gives 0xDF, of 0x00 gives 0x90, and of 0x2F gives 0x9F.
- R4: Bit 7 of the seconds slot is a stop flag. Every seconds write sets or clears it, whether or not the seconds value is accepted. While the flag is set, ticks do not change the time. A seconds read returns the flag in bit 7 and the BCD seconds in bits 6..0.
- R5: A seconds or minutes write uses bits 6..0 as BCD and is accepted only for 00..59.
- R6: An hours write uses bits 5..0 as BCD and is accepted only for 00..23.
- R7: A weekday write takes bits 2..0 as the weekday, accepted only for 1..7, and always stores bit 6 as the century flag. A read returns the century flag in bit 6 and the weekday in bits 2..0, with all other bits zero.
- R8: A date write uses bits 5..0 as BCD and is accepted for 01..31. A month write uses bits 4..0 and is accepted for 01..12. A year write uses all 8 bits and is accepted for BCD 00..99. A rejected write leaves the field unchanged.
- R9: After reset the registers read as follows: control 0x90, seconds 0x00, minutes 0x00, hours 0x00, weekday 0x01, date 0x01, month 0x01, year 0x00.
- R10: Each tick advances the seconds. 59 wraps to 00 and carries into the minutes, minutes carry into the hours, and hours carry from 23 into a new day. On a new day the weekday goes from 7 to 1, and otherwise up by one.
- R11: On a new day, the date wraps to 01 after the month's last day (30 or 31 days, and February 29 when the year is divisible by 4, otherwise 28). Month 12 wraps to 01 and carries into the year, and year 99 wraps to 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timekeeping clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W | Byte address |
| wrData | input | 8 | Write data |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| tick | input | 1 | One-cycle pulse, once per second |
| rdData | output | 8 | Registered read data |

## Verification
The counting and freeze properties assume that a tick coincides with no write to the register window. They assume that only one bus operation is active in any cycle, so a read never meets a write to the same byte. The directed bench drives each write, read and tick in its own clock cycle, from the falling edge. That keeps every property within its premise. The field-range properties hold at all times, because a rejected write can never put an out-of-range value into a field.

// File: rtl/tod_pkg.sv
`timescale 1ns/1ps
package tod_pkg;

  typedef enum logic [2:0] {
    SLOT_CTRL, SLOT_SEC, SLOT_MIN, SLOT_HOUR,
    SLOT_WDAY, SLOT_DATE, SLOT_MONTH, SLOT_YEAR
  } tod_slot_e;

  typedef struct packed {
    logic       ramWr;
    logic       ramRd;
    logic       regRd;
    logic [7:0] regWr;
    logic [2:0] regSel;
    logic       tick;
  } tod_strobe_t;

  typedef struct packed {
    logic       stop;
    logic       century;
    logic [7:0] ctrl;
    logic [5:0] sec;
    logic [5:0] min;
    logic [4:0] hour;
    logic [2:0] wday;
    logic [4:0] date;
    logic [3:0] month;
    logic [6:0] year;
  } tod_time_t;

  localparam tod_time_t RESET_TIME = '{stop: 1'b0, century: 1'b0, ctrl: 8'h90,
    sec: 6'd0, min: 6'd0, hour: 5'd0, wday: 3'd1, date: 5'd1, month: 4'd1, year: 7'd0};

  function automatic logic bcdOk(input logic [7:0] v);
    return (v[7:4] <= 4'd9) && (v[3:0] <= 4'd9);
  endfunction

  function automatic logic [6:0] bcdToBin(input logic [7:0] v);
    return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
  endfunction

  function automatic logic [7:0] binToBcd(input logic [6:0] v);
    logic [3:0] tens, ones;
    tens = 4'(v / 7'd10);
    ones = 4'(v % 7'd10);
    return {tens, ones};
  endfunction

  function automatic logic [4:0] monthDays(input logic [3:0] m, input logic [6:0] y);
    case (m)
      4'd2:                      return (y[1:0] == 2'd0) ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   return 5'd30;
      default:                   return 5'd31;
    endcase
  endfunction

endpackage

// File: rtl/tod_ctrl.sv
`timescale 1ns/1ps
module tod_ctrl
  import tod_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              tick,
  output tod_strobe_t       strobes
);
  localparam int WIN_BITS = 3;

  logic inWindow;
  assign inWindow = &addr[ADDR_W-1:WIN_BITS];

  always_comb begin
    strobes.ramWr  = wrEn && !inWindow;
    strobes.ramRd  = rdEn && !inWindow;
    strobes.regRd  = rdEn && inWindow;
    strobes.regSel = addr[WIN_BITS-1:0];
    strobes.regWr  = (wrEn && inWindow) ? (8'b1 << addr[WIN_BITS-1:0]) : 8'b0;
    strobes.tick   = tick;
  end
endmodule

// File: rtl/tod_datapath.sv
`timescale 1ns/1ps
module tod_datapath
  import tod_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tod_strobe_t       strobes,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  output tod_time_t         timeNow
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];
  tod_time_t  cur, nxt;
  logic [4:0] lastDay;
  logic [7:0] regByte;
  logic [6:0] wBin7, wBin6, wBin5, wBinY;

  assign timeNow = cur;
  assign lastDay = monthDays(cur.month, cur.year);
  assign wBin7   = bcdToBin({1'b0, wrData[6:0]});
  assign wBin6   = bcdToBin({2'b0, wrData[5:0]});
  assign wBin5   = bcdToBin({3'b0, wrData[4:0]});
  assign wBinY   = bcdToBin(wrData);

  always_ff @(posedge clk) begin
    if (strobes.ramWr) mem[addr] <= wrData;
  end

  // Tick carry chain first, then any register write overlays its own field.
  always_comb begin
    nxt = cur;
    if (strobes.tick && !cur.stop) begin
      if (cur.sec != 6'd59) nxt.sec = cur.sec + 6'd1;
      else begin
        nxt.sec = 6'd0;
        if (cur.min != 6'd59) nxt.min = cur.min + 6'd1;
        else begin
          nxt.min = 6'd0;
          if (cur.hour != 5'd23) nxt.hour = cur.hour + 5'd1;
          else begin
            nxt.hour = 5'd0;
            nxt.wday = (cur.wday == 3'd7) ? 3'd1 : cur.wday + 3'd1;
            if (cur.date < lastDay) nxt.date = cur.date + 5'd1;
            else begin
              nxt.date = 5'd1;
              if (cur.month != 4'd12) nxt.month = cur.month + 4'd1;
              else begin
                nxt.month = 4'd1;
                nxt.year  = (cur.year == 7'd99) ? 7'd0 : cur.year + 7'd1;
              end
            end
          end
        end
      end
    end
    if (strobes.regWr[SLOT_CTRL]) nxt.ctrl = (wrData & 8'hDF) | 8'h90;
    if (strobes.regWr[SLOT_SEC]) begin
      nxt.stop = wrData[7];
      if (bcdOk({1'b0, wrData[6:0]}) && wBin7 <= 7'd59) nxt.sec = wBin7[5:0];
    end
    if (strobes.regWr[SLOT_MIN] && bcdOk({1'b0, wrData[6:0]}) && wBin7 <= 7'd59)
      nxt.min = wBin7[5:0];
    if (strobes.regWr[SLOT_HOUR] && bcdOk({2'b0, wrData[5:0]}) && wBin6 <= 7'd23)
      nxt.hour = wBin6[4:0];
    if (strobes.regWr[SLOT_WDAY]) begin
      nxt.century = wrData[6];
      if (wrData[2:0] != 3'd0) nxt.wday = wrData[2:0];
    end
    if (strobes.regWr[SLOT_DATE] && bcdOk({2'b0, wrData[5:0]}) &&
        wBin6 >= 7'd1 && wBin6 <= 7'd31)
      nxt.date = wBin6[4:0];
    if (strobes.regWr[SLOT_MONTH] && bcdOk({3'b0, wrData[4:0]}) &&
        wBin5 >= 7'd1 && wBin5 <= 7'd12)
      nxt.month = wBin5[3:0];
    if (strobes.regWr[SLOT_YEAR] && bcdOk(wrData))
      nxt.year = wBinY;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur <= RESET_TIME;
    else        cur <= nxt;
  end

  always_comb begin
    case (tod_slot_e'(strobes.regSel))
      SLOT_CTRL:  regByte = cur.ctrl;
      SLOT_SEC:   regByte = {cur.stop, binToBcd({1'b0, cur.sec})[6:0]};
      SLOT_MIN:   regByte = binToBcd({1'b0, cur.min});
      SLOT_HOUR:  regByte = binToBcd({2'b0, cur.hour});
      SLOT_WDAY:  regByte = {1'b0, cur.century, 3'b000, cur.wday};
      SLOT_DATE:  regByte = binToBcd({2'b0, cur.date});
      SLOT_MONTH: regByte = binToBcd({3'b0, cur.month});
      default:    regByte = binToBcd(cur.year);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              rdData <= 8'h00;
    else if (strobes.ramRd)  rdData <= mem[addr];
    else if (strobes.regRd)  rdData <= regByte;
  end
endmodule

// File: rtl/tod_ram.sv
`timescale 1ns/1ps
module tod_ram
  import tod_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              tick,
  output logic [7:0]        rdData
);
  tod_strobe_t strobes;
  tod_time_t   timeNow;

  tod_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .addr(addr), .wrEn(wrEn), .rdEn(rdEn), .tick(tick), .strobes(strobes)
  );

  tod_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .addr(addr),
    .wrData(wrData), .rdData(rdData), .timeNow(timeNow)
  );
endmodule

// File: rtl/tod_ram_checker.sv
`timescale 1ns/1ps
module tod_ram_checker
  import tod_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wrEn,
  input logic              rdEn,
  input logic              tick,
  input logic [7:0]        rdData,
  input tod_strobe_t       strobes,
  input tod_time_t         timeNow
);
  logic inWindow, ctrlRead;
  assign inWindow = &addr[ADDR_W-1:3];
  assign ctrlRead = rdEn && inWindow && (addr[2:0] == 3'd0);

  assert_rd_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rdEn |=> $stable(rdData));

  assert_one_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobes.regWr));

  assert_ctrl_form_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrlRead |=> (rdData & 8'hB0) == 8'h90);

  assert_stop_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (timeNow.stop && !(wrEn && inWindow)) |=> $stable(timeNow));

  assert_sec_min_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    timeNow.sec <= 6'd59 && timeNow.min <= 6'd59);

  assert_hour_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    timeNow.hour <= 5'd23);

  assert_wday_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    timeNow.wday != 3'd0);

  assert_date_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    timeNow.date != 5'd0 && timeNow.month != 4'd0 && timeNow.month <= 4'd12 &&
    timeNow.year <= 7'd99);

  assert_sec_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !timeNow.stop && !(wrEn && inWindow) && timeNow.sec != 6'd59)
      |=> timeNow.sec == $past(timeNow.sec) + 6'd1);
endmodule

bind tod_ram tod_ram_checker #(.ADDR_W(ADDR_W)) chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
  .tick(tick), .rdData(rdData), .strobes(strobes), .timeNow(timeNow)
);

// File: tb/tod_ram_test.sv
`timescale 1ns/1ps
module tod_ram_test;
  localparam int ADDR_W = 11;
  localparam logic [ADDR_W-1:0] WIN = 11'h7F8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0] wrData = 8'h00;
  logic wrEn = 1'b0, rdEn = 1'b0, tick = 1'b0;
  logic [7:0] rdData;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tod_ram #(.ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wrData(wrData),
    .wrEn(wrEn), .rdEn(rdEn), .tick(tick), .rdData(rdData)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [ADDR_W-1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rdEn = 1'b1;
    @(negedge clk); rdEn = 1'b0; d = rdData;
  endtask

  task automatic regCheck(input string tag, input int slot, input logic [7:0] exp);
    logic [7:0] v;
    busRead(WIN + ADDR_W'(slot), v);
    check(tag, v, exp);
  endtask

  task automatic pulseTick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic setAll(input logic [7:0] hr, mi, se, wd, dt, mo, yr);
    busWrite(WIN + 3, hr); busWrite(WIN + 2, mi); busWrite(WIN + 1, se);
    busWrite(WIN + 4, wd); busWrite(WIN + 7, yr); busWrite(WIN + 6, mo);
    busWrite(WIN + 5, dt);
  endtask

  task automatic testReset();
    regCheck("R9 ctrl", 0, 8'h90);  regCheck("R9 sec", 1, 8'h00);
    regCheck("R9 min", 2, 8'h00);   regCheck("R9 hour", 3, 8'h00);
    regCheck("R9 wday", 4, 8'h01);  regCheck("R9 date", 5, 8'h01);
    regCheck("R9 month", 6, 8'h01); regCheck("R9 year", 7, 8'h00);
  endtask

  task automatic testRam();
    logic [7:0] v;
    busWrite(11'h000, 8'hA5); busWrite(11'h123, 8'h5A); busWrite(11'h7F7, 8'h3C);
    busRead(11'h000, v); check("R1 ram low", v, 8'hA5);
    busRead(11'h123, v); check("R1 ram mid", v, 8'h5A);
    busRead(11'h7F7, v); check("R2 ram just below window", v, 8'h3C);
    @(negedge clk); @(negedge clk);
    check("R1 rdData holds without rdEn", rdData, 8'h3C);
    regCheck("R2 window control untouched by RAM write", 0, 8'h90);
  endtask

  task automatic testCtrl();
    busWrite(WIN, 8'hFF); regCheck("R3 ctrl 0xFF", 0, 8'hDF);
    busWrite(WIN, 8'h00); regCheck("R3 ctrl 0x00", 0, 8'h90);
    busWrite(WIN, 8'h2F); regCheck("R3 ctrl 0x2F", 0, 8'h9F);
  endtask

  task automatic testFields();
    busWrite(WIN + 1, 8'h45); regCheck("R5 sec 45", 1, 8'h45);
    busWrite(WIN + 1, 8'h60); regCheck("R5 sec 60 rejected", 1, 8'h45);
    busWrite(WIN + 1, 8'h4A); regCheck("R5 sec non-BCD rejected", 1, 8'h45);
    busWrite(WIN + 2, 8'h59); regCheck("R5 min 59", 2, 8'h59);
    busWrite(WIN + 2, 8'h7F); regCheck("R5 min 7F rejected", 2, 8'h59);
    busWrite(WIN + 3, 8'h23); regCheck("R6 hour 23", 3, 8'h23);
    busWrite(WIN + 3, 8'h24); regCheck("R6 hour 24 rejected", 3, 8'h23);
    busWrite(WIN + 3, 8'hD2); regCheck("R6 hour masked to 12", 3, 8'h12);
    busWrite(WIN + 5, 8'h00); regCheck("R8 date 00 rejected", 5, 8'h01);
    busWrite(WIN + 5, 8'h31); regCheck("R8 date 31", 5, 8'h31);
    busWrite(WIN + 5, 8'h32); regCheck("R8 date 32 rejected", 5, 8'h31);
    busWrite(WIN + 6, 8'h13); regCheck("R8 month 13 rejected", 6, 8'h01);
    busWrite(WIN + 6, 8'hE9); regCheck("R8 month masked to 09", 6, 8'h09);
    busWrite(WIN + 7, 8'h99); regCheck("R8 year 99", 7, 8'h99);
    busWrite(WIN + 7, 8'h9A); regCheck("R8 year non-BCD rejected", 7, 8'h99);
  endtask

  task automatic testWeekday();
    busWrite(WIN + 4, 8'h45); regCheck("R7 century and weekday 5", 4, 8'h45);
    busWrite(WIN + 4, 8'h08); regCheck("R7 weekday 0 rejected, century cleared", 4, 8'h05);
  endtask

  task automatic testStop();
    busWrite(WIN + 1, 8'h90); regCheck("R4 stop set, sec 10", 1, 8'h90);
    pulseTick(); pulseTick(); pulseTick();
    regCheck("R4 ticks ignored while stopped", 1, 8'h90);
    busWrite(WIN + 1, 8'hFF); regCheck("R4 stop kept on rejected value", 1, 8'h90);
    busWrite(WIN + 1, 8'h10); pulseTick();
    regCheck("R4 running after clear", 1, 8'h11);
  endtask

  task automatic testRollover();
    setAll(8'h23, 8'h59, 8'h59, 8'h07, 8'h15, 8'h03, 8'h24);
    pulseTick();
    regCheck("R10 sec wrap", 1, 8'h00);  regCheck("R10 min wrap", 2, 8'h00);
    regCheck("R10 hour wrap", 3, 8'h00); regCheck("R10 weekday 7 to 1", 4, 8'h01);
    regCheck("R10 date step", 5, 8'h16);
    busWrite(WIN + 2, 8'h14); busWrite(WIN + 1, 8'h59); pulseTick();
    regCheck("R10 minute carry", 2, 8'h15);
  endtask

  task automatic testMonthEnd();
    setAll(8'h23, 8'h59, 8'h59, 8'h03, 8'h30, 8'h04, 8'h23); pulseTick();
    regCheck("R11 April end date", 5, 8'h01); regCheck("R11 April end month", 6, 8'h05);
    regCheck("R10 weekday 3 to 4", 4, 8'h04);
    setAll(8'h23, 8'h59, 8'h59, 8'h01, 8'h28, 8'h02, 8'h24); pulseTick();
    regCheck("R11 leap Feb 29", 5, 8'h29); regCheck("R11 leap Feb month", 6, 8'h02);
    setAll(8'h23, 8'h59, 8'h59, 8'h01, 8'h29, 8'h02, 8'h24); pulseTick();
    regCheck("R11 leap Feb end date", 5, 8'h01); regCheck("R11 leap Feb end month", 6, 8'h03);
    setAll(8'h23, 8'h59, 8'h59, 8'h01, 8'h28, 8'h02, 8'h23); pulseTick();
    regCheck("R11 common Feb end date", 5, 8'h01); regCheck("R11 common Feb end month", 6, 8'h03);
    setAll(8'h23, 8'h59, 8'h59, 8'h01, 8'h31, 8'h12, 8'h99); pulseTick();
    regCheck("R11 year end date", 5, 8'h01); regCheck("R11 year end month", 6, 8'h01);
    regCheck("R11 year 99 to 00", 7, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    testReset();
    testRam();
    testCtrl();
    testFields();
    testWeekday();
    testStop();
    testRollover();
    testMonthEnd();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule